// File: doc/BRIEF.md
# Deferred Code/Data Read Strobe Swapper

This block takes two read requests from a simple CPU bus sequencer: a program-fetch request and an external data-move read request. It drives them onto two active-low read strobe pins. One pin normally enables the code memory. The other normally strobes the read input of an external RAM. A configuration bit selects which pin carries which function, so the two memories can trade roles at run time.

A write to the configuration bit does not redirect the strobes at once. When the written value differs from the value now in effect, it is held as a pending request. The new value is committed at the end of the next instruction that the sequencer reports as two cycles long. That instruction, normally a long jump, still runs under the old routing. The first fetch after it goes out on the pin that used to carry data reads. A status output shows the effective bit and the pending flag.

The requests are single-cycle level signals with no handshake. The strobes follow them combinationally, with no back-pressure path. The sequencer must present a request only while the target memory can accept it.

Top module: `strobe_swap_top`

## Requirements
- R1: With the effective swap bit at 0, a fetch request drives `pin_a_n` low and a data read request drives `pin_b_n` low.
- R2: With the effective swap bit at 1, a fetch request drives `pin_b_n` low and a data read request drives `pin_a_n` low.
- R3: A write whose value differs from the effective bit raises `stat_pending` on the following cycle. The routing and `stat_swap` stay unchanged until a commit.
- R4: A commit happens at the clock edge that ends the first cycle, after the write, in which `insn_end` is high, `insn_cycles` equals 2 and a request is pending. Boundaries with any other cycle count change nothing. After a commit, `stat_swap` holds the requested value, `stat_pending` is 0, and requests in the next cycle use the new routing.
- R5: Both strobes are high when neither request is asserted, and never more than one strobe is low. When fetch and data requests are asserted together, only the fetch strobe is driven.
- R6: A write whose value equals the effective bit leaves `stat_pending` at 0 and the routing unchanged. If a request is pending, such a write cancels it.
- R7: After reset, `stat_swap` and `stat_pending` are both 0, so the default routing of R1 applies.
- R8: A write in the same cycle as a qualifying boundary takes precedence. That boundary commits nothing, and the pending state is set from the new write alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration bit write strobe |
| cfg_wr_swap | input | 1 | Value written to the swap bit |
| fetch_req | input | 1 | Program-fetch read request |
| data_req | input | 1 | External data-move read request |
| insn_end | input | 1 | Pulse in the last cycle of an instruction |
| insn_cycles | input | CNT_W | Cycle count of the instruction ending this cycle |
| pin_a_n | output | 1 | Strobe to code memory output enable (active low) |
| pin_b_n | output | 1 | Strobe to external RAM read input (active low) |
| stat_swap | output | 1 | Effective swap bit |
| stat_pending | output | 1 | A swap change is waiting for a boundary |

## Verification
The routing is swept over all four fetch/data request combinations under both swap values. This separates correct pin selection from a swapped or stuck mapping, and it separates fetch priority from data priority in a collision. The commit rule is tried with a pending request at a boundary of every cycle count from 0 to 7. Only a count of 2 may commit, which exposes an off-by-one or an ignored count. Same-value writes, cancelling writes and a write that collides with a boundary show whether the pending flag compares against the effective bit and whether a write takes precedence.

// File: rtl/strobe_swap_pkg.sv
package strobe_swap_pkg;

  typedef struct packed {
    logic fetch;
    logic data;
  } grant_t;

  function automatic grant_t arbitrate(input logic fetch, input logic data,
                                       input logic fetch_first);
    grant_t g;
    if (fetch_first) begin
      g.fetch = fetch;
      g.data  = data & ~fetch;
    end else begin
      g.data  = data;
      g.fetch = fetch & ~data;
    end
    return g;
  endfunction

endpackage

// File: rtl/swap_ctrl.sv
module swap_ctrl #(
  parameter int CNT_W      = 3,
  parameter int COMMIT_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_val,
  input  logic             bnd,
  input  logic [CNT_W-1:0] bnd_cycles,
  output logic             swap_q,
  output logic             pend_q
);
  localparam logic [CNT_W-1:0] COMMIT_CNT = CNT_W'(COMMIT_LEN);

  logic target_q;
  logic commit;

  // a write in the same cycle wins over the boundary
  assign commit = pend_q && bnd && (bnd_cycles == COMMIT_CNT) && !wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap_q   <= 1'b0;
      pend_q   <= 1'b0;
      target_q <= 1'b0;
    end else if (wr_en) begin
      pend_q   <= (wr_val != swap_q);
      target_q <= wr_val;
    end else if (commit) begin
      swap_q <= target_q;
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/strobe_router.sv
module strobe_router #(
  parameter bit FETCH_FIRST = 1'b1
) (
  input  logic fetch_req,
  input  logic data_req,
  input  logic swap,
  output logic pin_a_n,
  output logic pin_b_n
);
  import strobe_swap_pkg::*;

  grant_t g;
  logic   a_act, b_act;

  assign g = arbitrate(fetch_req, data_req, FETCH_FIRST);

  always_comb begin
    if (swap) begin
      a_act = g.data;
      b_act = g.fetch;
    end else begin
      a_act = g.fetch;
      b_act = g.data;
    end
  end

  assign pin_a_n = ~a_act;
  assign pin_b_n = ~b_act;
endmodule

// File: rtl/strobe_swap_top.sv
module strobe_swap_top #(
  parameter int CNT_W      = 3,
  parameter int COMMIT_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic             cfg_wr_swap,
  input  logic             fetch_req,
  input  logic             data_req,
  input  logic             insn_end,
  input  logic [CNT_W-1:0] insn_cycles,
  output logic             pin_a_n,
  output logic             pin_b_n,
  output logic             stat_swap,
  output logic             stat_pending
);
  swap_ctrl #(.CNT_W(CNT_W), .COMMIT_LEN(COMMIT_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_val(cfg_wr_swap),
    .bnd(insn_end), .bnd_cycles(insn_cycles),
    .swap_q(stat_swap), .pend_q(stat_pending)
  );

  strobe_router #(.FETCH_FIRST(1'b1)) u_route (
    .fetch_req(fetch_req), .data_req(data_req), .swap(stat_swap),
    .pin_a_n(pin_a_n), .pin_b_n(pin_b_n)
  );
endmodule

// File: rtl/strobe_swap_chk.sv
module strobe_swap_chk #(
  parameter int CNT_W      = 3,
  parameter int COMMIT_LEN = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic             cfg_wr_swap,
  input logic             fetch_req,
  input logic             data_req,
  input logic             insn_end,
  input logic [CNT_W-1:0] insn_cycles,
  input logic             pin_a_n,
  input logic             pin_b_n,
  input logic             stat_swap,
  input logic             stat_pending
);
  localparam logic [CNT_W-1:0] CC = CNT_W'(COMMIT_LEN);

  p_fetch_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !stat_swap) |-> !pin_a_n);
  p_fetch_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && stat_swap) |-> !pin_b_n);
  p_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_swap != stat_swap) |=> (stat_pending && stat_swap == $past(stat_swap)));
  p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_end && insn_cycles == CC && stat_pending && !cfg_wr_en) |=> (!stat_pending && stat_swap != $past(stat_swap)));
  p_no_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(insn_end && insn_cycles == CC)) |=> (stat_swap == $past(stat_swap)));
  p_one_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~pin_a_n, ~pin_b_n}) <= 1);
  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_req && !data_req) |-> (pin_a_n && pin_b_n));
  p_same_val_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_swap == stat_swap) |=> (!stat_pending && stat_swap == $past(stat_swap)));
endmodule

bind strobe_swap_top strobe_swap_chk #(.CNT_W(CNT_W), .COMMIT_LEN(COMMIT_LEN)) u_chk (.*);

// File: tb/tb_strobe_swap_top.sv
module tb_strobe_swap_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr_en = 0, cfg_wr_swap = 0, fetch_req = 0, data_req = 0, insn_end = 0;
  logic [2:0] insn_cycles = 0;
  logic pin_a_n, pin_b_n, stat_swap, stat_pending;
  int checks = 0, fails = 0;
  logic m_swap = 0, m_pend = 0, m_tgt = 0;

  always #5 clk = ~clk;

  strobe_swap_top dut (.*);

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one cycle: drive, check strobes, clock, update model, check status
  task automatic cyc(input string sreq, input logic wr, input logic val, input logic bnd,
                     input logic [2:0] cnt, input logic f, input logic d);
    logic fg, dg;
    cfg_wr_en = wr; cfg_wr_swap = val; insn_end = bnd; insn_cycles = cnt;
    fetch_req = f; data_req = d;
    #1;
    fg = f; dg = d & ~f;
    chk((!f && !d) || (f && d) ? "R5" : (m_swap ? "R2" : "R1"), {pin_a_n, pin_b_n},
        {~(m_swap ? dg : fg), ~(m_swap ? fg : dg)});
    @(posedge clk);
    if (wr) begin m_pend = (val != m_swap); m_tgt = val; end
    else if (bnd && cnt == 3'd2 && m_pend) begin m_swap = m_tgt; m_pend = 0; end
    #1;
    chk(sreq, {stat_swap, stat_pending}, {m_swap, m_pend});
    cfg_wr_en = 0; insn_end = 0; fetch_req = 0; data_req = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    #1; rst_n = 1'b1;
    chk("R7", {stat_swap, stat_pending}, 2'b00);
    chk("R7", {pin_a_n, pin_b_n}, 2'b11);
    // R1/R5 routing sweep with swap 0
    for (int r = 0; r < 4; r++) cyc("R1", 0, 0, 0, 0, r[1], r[0]);
    // R4: boundary count sweep, only count 2 commits
    for (int c = 0; c < 8; c++) begin
      cyc("R3", 1, 1, 0, 0, 1, 0);
      cyc("R3", 0, 0, 0, 0, 1, 1);   // pending: old routing still used
      cyc("R4", 0, 0, 1, 3'(c), 1, 0);
      cyc("R4", 0, 0, 0, 0, 1, 0);   // next fetch sees routing of model
      if (m_swap) begin
        cyc("R3", 1, 0, 0, 0, 0, 0);
        cyc("R4", 0, 0, 1, 3'd2, 0, 1);
      end else begin
        cyc("R6", 1, 0, 0, 0, 0, 0); // cancel
      end
    end
    // move to swap 1 and sweep routing (R2/R5)
    cyc("R3", 1, 1, 0, 0, 0, 0);
    cyc("R4", 0, 0, 1, 3'd2, 0, 0);
    for (int r = 0; r < 4; r++) cyc("R2", 0, 0, 0, 0, r[1], r[0]);
    // R6: same-value write sets nothing
    cyc("R6", 1, 1, 0, 0, 1, 0);
    cyc("R6", 0, 0, 1, 3'd2, 1, 0);
    // R6: differing then equal write cancels
    cyc("R3", 1, 0, 0, 0, 0, 1);
    cyc("R6", 1, 1, 0, 0, 0, 1);
    cyc("R6", 0, 0, 1, 3'd2, 1, 0);
    // R8: write collides with qualifying boundary
    cyc("R3", 1, 0, 0, 0, 0, 0);
    cyc("R8", 1, 1, 1, 3'd2, 0, 0);   // cancels, no commit
    cyc("R8", 0, 0, 1, 3'd2, 1, 0);
    cyc("R3", 1, 0, 0, 0, 0, 0);
    cyc("R8", 1, 0, 1, 3'd2, 0, 0);   // re-requests, still pending
    cyc("R8", 0, 0, 0, 0, 1, 0);
    cyc("R4", 0, 0, 1, 3'd2, 0, 1);
    for (int r = 0; r < 4; r++) cyc("R1", 0, 0, 0, 0, r[1], r[0]);
    finish_run();
  end
endmodule